// File: doc/BRIEF.md
# TDM Receive Bit-Mask Deserializer

This block sits behind a time-division highway receiver. It takes one data bit per strobe, together with that bit's position inside the current time slot. A per-position mask selects which positions carry payload for this channel. Positions that are masked out are thrown away. The surviving bits are packed, least significant bit first, into an assembly register. Each time eight surviving bits have been gathered, the finished byte goes into a small internal receive buffer.

Because masked positions are removed before assembly, an assembled byte usually spans several time slots. The partial byte therefore carries over from one slot to the next. Masking takes effect only while highway mode is selected. Outside that mode, every strobed bit counts as payload.

The buffer reports its occupancy and raises a level interrupt once the occupancy reaches a programmable fill threshold. A byte that completes while the buffer is full is dropped, and a sticky overflow flag records the loss. Turning the receiver off clears the partial byte and the overflow flag but leaves buffered bytes in place.

Top module: `tdm_rx_mask_deser`

## Requirements
- R1: With `hwy_mode`=1 and `rx_enable`=1, a strobed bit whose mask bit `rx_mask[bit_pos]` is 0 is discarded and does not advance byte assembly. A mask bit of 1 means that position is kept.
- R2: With `hwy_mode`=0, every strobed bit is kept, whatever the value of `rx_mask`.
- R3: Kept bits are packed least significant bit first: the first kept bit of a byte lands in bit 0 of the stored byte and the eighth kept bit lands in bit 7.
- R4: A byte is written when its eighth kept bit arrives, on that clock edge (`wr_en` is high in the same cycle). The partial count carries across slot boundaries, so one byte may gather bits from several slots.
- R5: While `rx_enable`=0, strobed bits are ignored. A low `rx_enable` also clears the partial byte, so assembly restarts from an empty byte once the receiver is enabled again.
- R6: Stored bytes are read out in arrival order. `rd_data` shows the oldest byte whenever `rd_valid`=1, and `fill_count` equals the number of stored bytes.
- R7: `fill_irq` is 1 exactly when `fill_level` is non-zero and `fill_count` >= `fill_level`. A level of 0 keeps the interrupt off, and a level of 1 flags every stored byte.
- R8: A byte that completes while the buffer holds `FIFO_DEPTH` bytes is dropped, even if a read happens in the same cycle. This also sets `overflow`, which stays at 1 until reset or until `rx_enable` goes low.
- R9: A read request while the buffer is empty is ignored and does not disturb later writes or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enable; low clears the partial byte and the overflow flag |
| hwy_mode | input | 1 | 1 = highway mode, so the mask applies |
| bit_strobe | input | 1 | One received bit is present this cycle |
| bit_pos | input | POS_W (3) | Position of the bit inside its slot, 0 to SLOT_BITS-1 |
| bit_data | input | 1 | Received bit value |
| rx_mask | input | SLOT_BITS (8) | Per-position keep mask, 1 = keep |
| fill_level | input | FILL_W (3) | Interrupt threshold, 0 = interrupt off |
| rd_en | input | 1 | Pop the oldest stored byte |
| rd_data | output | BYTE_W (8) | Oldest stored byte |
| rd_valid | output | 1 | Buffer not empty |
| fill_count | output | FILL_W (3) | Number of stored bytes |
| fill_irq | output | 1 | Occupancy has reached the threshold |
| overflow | output | 1 | Sticky flag: a byte was lost to a full buffer |
| wr_en | output | 1 | A byte completed this cycle |
| wr_data | output | BYTE_W (8) | The byte completing this cycle |

## Verification
The hardest state to reach is a byte completing at the exact moment the buffer is full. Normal draining never lets the buffer fill, and the overflow must be seen on the fifth completed byte, not on the fifth slot. The bench stops its draining monitor and completes exactly `FIFO_DEPTH` bytes in transparent mode. It then completes one more byte and checks that the count stays at depth, that the flag is set, and that the four bytes it drains afterwards are the original ones. Assembly that spans slots is driven with sparse masks (one kept position per slot, and no kept positions at all), so a count that wrongly resets at the slot boundary shows up as a misaligned byte.

// File: rtl/tdm_mask_pkg.sv
package tdm_mask_pkg;

   // One received bit after mask qualification
   typedef struct packed {
      logic take;
      logic data;
   } rx_bit_t;

   // Index width that never collapses to zero bits
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tdm_bit_gate.sv
module tdm_bit_gate
   import tdm_mask_pkg::*;
#(
   parameter int unsigned SLOT_BITS    = 8,
   parameter bit          MASK_SUPPORT = 1'b1,
   localparam int unsigned POS_W       = idx_w(SLOT_BITS)
) (
   input  logic                 rx_enable,
   input  logic                 strobe,
   input  logic                 hwy_mode,
   input  logic [POS_W-1:0]     bit_pos,
   input  logic                 bit_data,
   input  logic [SLOT_BITS-1:0] mask,
   output rx_bit_t              evt
);

   logic [SLOT_BITS-1:0] pos_hit;
   logic                 pos_kept;

   // one-hot decode of the bit position
   for (genvar i = 0; i < SLOT_BITS; i++) begin : g_dec
      assign pos_hit[i] = (bit_pos == POS_W'(i));
   end

   if (MASK_SUPPORT) begin : g_mask
      // mask applies only in highway mode
      assign pos_kept = !hwy_mode || (|(pos_hit & mask));
   end else begin : g_nomask
      assign pos_kept = 1'b1;
   end

   assign evt.take = rx_enable & strobe & pos_kept;
   assign evt.data = bit_data;

endmodule

// File: rtl/tdm_byte_assembler.sv
module tdm_byte_assembler
   import tdm_mask_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned CNT_W    = idx_w(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  rx_bit_t           evt,
   output logic              push,
   output logic [BYTE_W-1:0] push_byte,
   output logic [CNT_W-1:0]  part_cnt
);

   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] sh_next;
   logic              last;

   if (LSB_FIRST) begin : g_lsb
      // first bit ends up in bit 0 after BYTE_W shifts
      assign sh_next = {evt.data, shreg[BYTE_W-1:1]};
   end else begin : g_msb
      assign sh_next = {shreg[BYTE_W-2:0], evt.data};
   end

   assign last      = (part_cnt == CNT_W'(BYTE_W - 1));
   assign push      = evt.take & last & ~clear;
   assign push_byte = sh_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         part_cnt <= '0;
      end else if (clear) begin
         shreg    <= '0;
         part_cnt <= '0;
      end else if (evt.take) begin
         shreg    <= sh_next;
         part_cnt <= last ? '0 : part_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo
   import tdm_mask_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned DEPTH   = 4,
   localparam int unsigned PTR_W  = idx_w(DEPTH),
   localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [W-1:0]      push_data,
   input  logic              pop,
   output logic [W-1:0]      pop_data,
   output logic [FILL_W-1:0] fill,
   output logic              full,
   output logic              empty,
   input  logic              ovf_clear,
   output logic              overflow
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic             do_push, do_pop;

   assign full    = (fill == FILL_W'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      // pointers wrap on their own
      assign wr_inc = wr_ptr + PTR_W'(1);
      assign rd_inc = rd_ptr + PTR_W'(1);
   end else begin : g_wrap
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_inc;
         if (do_pop)  rd_ptr <= rd_inc;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + FILL_W'(1);
            2'b01:   fill <= fill - FILL_W'(1);
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           overflow <= 1'b0;
      else if (ovf_clear)   overflow <= 1'b0;
      else if (push & full) overflow <= 1'b1;
   end

   assign pop_data = mem[rd_ptr];

endmodule

// File: rtl/tdm_rx_mask_deser.sv
module tdm_rx_mask_deser
   import tdm_mask_pkg::*;
#(
   parameter int unsigned SLOT_BITS    = 8,
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned FIFO_DEPTH   = 4,
   parameter bit          MASK_SUPPORT = 1'b1,
   parameter bit          LSB_FIRST    = 1'b1,
   localparam int unsigned POS_W       = idx_w(SLOT_BITS),
   localparam int unsigned FILL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_enable,
   input  logic                 hwy_mode,
   input  logic                 bit_strobe,
   input  logic [POS_W-1:0]     bit_pos,
   input  logic                 bit_data,
   input  logic [SLOT_BITS-1:0] rx_mask,
   input  logic [FILL_W-1:0]    fill_level,
   input  logic                 rd_en,
   output logic [BYTE_W-1:0]    rd_data,
   output logic                 rd_valid,
   output logic [FILL_W-1:0]    fill_count,
   output logic                 fill_irq,
   output logic                 overflow,
   output logic                 wr_en,
   output logic [BYTE_W-1:0]    wr_data
);

   localparam int unsigned PC_W = idx_w(BYTE_W);

   initial begin
      if (SLOT_BITS < 2)  $error("SLOT_BITS must be at least 2");
      if (BYTE_W < 2)     $error("BYTE_W must be at least 2");
      if (FIFO_DEPTH < 2) $error("FIFO_DEPTH must be at least 2");
   end

   rx_bit_t           gated;
   logic [PC_W-1:0]   part_cnt;
   logic              fifo_full;
   logic              fifo_empty;

   tdm_bit_gate #(
      .SLOT_BITS   (SLOT_BITS),
      .MASK_SUPPORT(MASK_SUPPORT)
   ) u_gate (
      .rx_enable(rx_enable),
      .strobe   (bit_strobe),
      .hwy_mode (hwy_mode),
      .bit_pos  (bit_pos),
      .bit_data (bit_data),
      .mask     (rx_mask),
      .evt      (gated)
   );

   tdm_byte_assembler #(
      .BYTE_W   (BYTE_W),
      .LSB_FIRST(LSB_FIRST)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!rx_enable),
      .evt      (gated),
      .push     (wr_en),
      .push_byte(wr_data),
      .part_cnt (part_cnt)
   );

   tdm_rx_fifo #(
      .W    (BYTE_W),
      .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wr_en),
      .push_data(wr_data),
      .pop      (rd_en),
      .pop_data (rd_data),
      .fill     (fill_count),
      .full     (fifo_full),
      .empty    (fifo_empty),
      .ovf_clear(!rx_enable),
      .overflow (overflow)
   );

   assign rd_valid = !fifo_empty;
   assign fill_irq = (fill_level != '0) && (fill_count >= fill_level);

endmodule

// File: rtl/tdm_rx_mask_deser_chk.sv
module tdm_rx_mask_deser_chk #(
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned POS_W      = 3,
   parameter int unsigned FILL_W     = 3,
   parameter int unsigned PC_W       = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rx_enable,
   input logic                 hwy_mode,
   input logic                 bit_strobe,
   input logic [POS_W-1:0]     bit_pos,
   input logic [SLOT_BITS-1:0] rx_mask,
   input logic [PC_W-1:0]      part_cnt,
   input logic                 wr_en,
   input logic                 fifo_full,
   input logic                 rd_en,
   input logic                 rd_valid,
   input logic [FILL_W-1:0]    fill_count,
   input logic [FILL_W-1:0]    fill_level,
   input logic                 fill_irq,
   input logic                 overflow
);

   logic [PC_W-1:0] pc_succ;
   assign pc_succ = (part_cnt == PC_W'(BYTE_W - 1)) ? '0 : part_cnt + PC_W'(1);

   // R1: a masked position leaves the partial count untouched
   a_r1_masked_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && bit_strobe && hwy_mode && !rx_mask[bit_pos] |=> $stable(part_cnt));

   // R2: outside highway mode every strobed bit advances the count
   a_r2_all_taken: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enable && bit_strobe && !hwy_mode |=> part_cnt == $past(pc_succ));

   // R4: a completed byte restarts assembly
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> part_cnt == '0);

   // R5: disabled receiver holds an empty partial byte
   a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> part_cnt == '0);

   // R6: occupancy never exceeds the depth
   a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= FILL_W'(FIFO_DEPTH));

   // R6: an accepted write without a read grows occupancy by one
   a_r6_fill_up: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !fifo_full && !(rd_en && rd_valid) |=> fill_count == $past(fill_count) + FILL_W'(1));

   // R7: a zero threshold keeps the interrupt low
   a_r7_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level == '0 |-> !fill_irq);

   // R8: a write into a full buffer is lost and flagged
   a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && fifo_full |=> overflow);

   a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && fifo_full && !rd_en |=> fill_count == $past(fill_count));

   // R9: an empty read with no write leaves the buffer empty
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_valid && !wr_en |=> fill_count == '0);

endmodule

bind tdm_rx_mask_deser tdm_rx_mask_deser_chk #(
   .SLOT_BITS (SLOT_BITS),
   .BYTE_W    (BYTE_W),
   .FIFO_DEPTH(FIFO_DEPTH),
   .POS_W     (POS_W),
   .FILL_W    (FILL_W),
   .PC_W      (PC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_enable (rx_enable),
   .hwy_mode  (hwy_mode),
   .bit_strobe(bit_strobe),
   .bit_pos   (bit_pos),
   .rx_mask   (rx_mask),
   .part_cnt  (part_cnt),
   .wr_en     (wr_en),
   .fifo_full (fifo_full),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .fill_count(fill_count),
   .fill_level(fill_level),
   .fill_irq  (fill_irq),
   .overflow  (overflow)
);

// File: tb/test_tdm_rx_mask_deser.sv
`timescale 1ns/1ps
module test_tdm_rx_mask_deser;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_enable = 1'b0;
   logic       hwy_mode = 1'b0;
   logic       bit_strobe = 1'b0;
   logic [2:0] bit_pos = '0;
   logic       bit_data = 1'b0;
   logic [7:0] rx_mask = 8'hFF;
   logic [2:0] fill_level = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic [2:0] fill_count;
   logic       fill_irq;
   logic       overflow;
   logic       wr_en;
   logic [7:0] wr_data;

   tdm_rx_mask_deser i_tdm_rx_mask_deser (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .hwy_mode(hwy_mode),
      .bit_strobe(bit_strobe), .bit_pos(bit_pos), .bit_data(bit_data),
      .rx_mask(rx_mask), .fill_level(fill_level), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .fill_count(fill_count),
      .fill_irq(fill_irq), .overflow(overflow), .wr_en(wr_en), .wr_data(wr_data)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // scoreboard model
   logic [7:0] exp_q[$];
   logic [7:0] m_sh = '0;
   int         m_n = 0;
   int         exp_occ = 0;
   bit         m_ovf = 0;
   bit         auto_drain = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pop and compare whatever the design stores
   always @(negedge clk) begin
      if (auto_drain && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R6 unexpected byte", int'(rd_data), 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R6 byte order/content", int'(rd_data), int'(e));
         end
         exp_occ--;
         rd_en = 1'b1;
      end else begin
         rd_en = 1'b0;
      end
   end

   task automatic model_bit(input int pos, input bit d);
      if (!rx_enable) return;
      if (hwy_mode && !rx_mask[pos]) return;
      m_sh = {d, m_sh[7:1]};
      m_n++;
      if (m_n == 8) begin
         m_n = 0;
         if (exp_occ == DEPTH) m_ovf = 1;
         else begin
            exp_q.push_back(m_sh);
            exp_occ++;
         end
      end
   endtask

   task automatic send_bit(input int pos, input bit d);
      @(negedge clk);
      bit_strobe = 1'b1;
      bit_pos    = pos[2:0];
      bit_data   = d;
      model_bit(pos, d);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bit_strobe = 1'b0;
      end
   endtask

   task automatic send_slot(input logic [7:0] v);
      for (int p = 0; p < 8; p++) send_bit(p, v[p]);
   endtask

   task automatic rx_off_pulse();
      @(negedge clk);
      bit_strobe = 1'b0;
      rx_enable  = 1'b0;
      m_n = 0; m_sh = '0; m_ovf = 0;
      @(negedge clk);
      rx_enable  = 1'b1;
   endtask

   task automatic drain();
      idle(1);
      auto_drain = 1;
      repeat (DEPTH * 3) @(negedge clk);
      auto_drain = 0;
      @(negedge clk);
      check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
      check(fill_count == 0, "R6 buffer empty after drain", int'(fill_count), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(fill_count == 0, "R6 reset fill", int'(fill_count), 0);
      check(!rd_valid, "R6 reset valid", int'(rd_valid), 0);
      check(!overflow, "R8 reset overflow", int'(overflow), 0);
      check(!fill_irq, "R7 reset irq", int'(fill_irq), 0);
      rx_enable = 1'b1;

      // R3: bit order, transparent mode
      hwy_mode = 0; rx_mask = 8'h00;
      send_slot(8'h01); idle(1);
      check(rd_data == 8'h01, "R3 first bit to bit0", int'(rd_data), 1);
      check(wr_en == 0, "R4 no write while idle", int'(wr_en), 0);
      drain();
      send_slot(8'h80); idle(1);
      check(rd_data == 8'h80, "R3 eighth bit to bit7", int'(rd_data), 8'h80);
      drain();

      // R2: mask ignored outside highway mode
      auto_drain = 1;
      send_slot(8'hA5); send_slot(8'h3C);
      drain();

      // R1/R4: highway mode, top position dropped, bytes span slots
      hwy_mode = 1; rx_mask = 8'h7F;
      auto_drain = 1;
      lfsr = 8'h5B;
      for (int s = 0; s < 8; s++) begin
         send_slot(lfsr);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      drain();
      check(m_n == 0, "R4 whole bytes after 8 slots of 7", m_n, 0);

      // R4: one kept position per slot, empty slots in between
      rx_mask = 8'h01; auto_drain = 1;
      for (int s = 0; s < 8; s++) begin
         send_slot(8'h0F ^ 8'(s));
         rx_mask = 8'h00;
         send_slot(8'hFF);
         rx_mask = 8'h01;
      end
      rx_mask = 8'h55;
      for (int s = 0; s < 6; s++) send_slot(8'h96 + 8'(s));
      drain();
      check(m_n == 0, "R1 sparse masks stay aligned", m_n, 0);

      // R5: disable clears a partial byte, disabled bits ignored
      hwy_mode = 0; auto_drain = 0;
      for (int p = 0; p < 5; p++) send_bit(p, 1'b1);
      idle(1);
      @(negedge clk);
      rx_enable = 1'b0;
      m_n = 0; m_sh = '0;
      for (int p = 0; p < 3; p++) send_bit(p, 1'b1);
      idle(1);
      check(fill_count == 0, "R5 nothing stored while disabled", int'(fill_count), 0);
      rx_enable = 1'b1;
      send_slot(8'h5A); idle(1);
      check(fill_count == 1, "R5 restart from empty byte", int'(fill_count), 1);
      check(rd_data == 8'h5A, "R5 byte aligned after re-enable", int'(rd_data), 8'h5A);
      drain();

      // R7: interrupt threshold
      fill_level = 3'd3;
      send_slot(8'h11); send_slot(8'h22); idle(1);
      check(!fill_irq, "R7 below threshold", int'(fill_irq), 0);
      send_slot(8'h33); idle(1);
      check(fill_irq, "R7 at threshold", int'(fill_irq), 1);
      fill_level = 3'd0; #1;
      check(!fill_irq, "R7 level zero off", int'(fill_irq), 0);
      drain();
      fill_level = 3'd1;
      send_slot(8'h44); idle(1);
      check(fill_irq, "R7 level one per byte", int'(fill_irq), 1);
      drain();
      check(!fill_irq, "R7 clears when empty", int'(fill_irq), 0);

      // R8: overflow on a full buffer
      for (int b = 0; b < DEPTH; b++) send_slot(8'hC0 + 8'(b));
      idle(1);
      check(fill_count == DEPTH, "R8 buffer full", int'(fill_count), DEPTH);
      check(!overflow, "R8 no overflow yet", int'(overflow), 0);
      send_slot(8'hEE); idle(1);
      check(overflow == m_ovf, "R8 overflow set", int'(overflow), int'(m_ovf));
      check(fill_count == DEPTH, "R8 dropped byte not stored", int'(fill_count), DEPTH);
      drain();
      check(overflow, "R8 overflow sticky", int'(overflow), 1);
      rx_off_pulse();
      idle(1);
      check(!overflow, "R8 disable clears overflow", int'(overflow), 0);

      // R9: read on empty buffer
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      check(fill_count == 0, "R9 empty read ignored", int'(fill_count), 0);
      send_slot(8'h69); idle(1);
      check(fill_count == 1, "R9 count after empty read", int'(fill_count), 1);
      check(rd_data == 8'h69, "R9 data after empty read", int'(rd_data), 8'h69);
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule